// File: doc/BRIEF.md
# Programmable Read Latency Equalizer

This block sits on the read data path of a memory device and holds back each read data word by a programmable number of clock cycles. The goal is for the round-trip read delay seen by the controller to match across every device on the channel. The total delay is a fixed three-cycle offset plus a column-latch core delay plus two delay fields, each with its own legal range. Software loads these fields through a small register port at three fixed addresses.

A read command arrives as a one-cycle strobe together with its data word. The same word leaves later with a one-cycle valid flag. The delay line takes a new strobe on every cycle. Register contents are undefined after reset, so reads are accepted only after each of the three registers has taken one legal write. Illegal writes, and strobes that arrive too early, raise a sticky error flag.

Top module: `read_lat_equalizer`

## Requirements
- R1: After reset, `q_valid`, `err_flag` and `cfg_ready` are all 0.
- R2: Address 0x048 holds three fields. The first delay is in bits [2:0], the latch delay in bits [5:4] and the strobe delay in bits [9:8]. A write there is taken only if bits [9:8] = 2'b10, bits [5:4] = 2'b10 and bits [2:0] are in 3..5. Any other write leaves the register unchanged and sets `err_flag`.
- R3: Address 0x049 holds the framing field in bits [3:0]. A write there is taken only if the value is in 7..10. Any other write leaves the register unchanged and sets `err_flag`.
- R4: Address 0x04A holds the second delay in bits [2:0]. A write there is taken only if the value is in 0..2. Any other write leaves the register unchanged and sets `err_flag`.
- R5: `cfg_rdata` shows the addressed register in the same cycle. Bits outside the fields read 0 and ignore writes. Other addresses read 0, and writes to them change nothing and raise no error.
- R6: `cfg_ready` rises once each of the three registers has taken at least one legal write since reset, and it stays high until reset.
- R7: A `rd_req` strobe while `cfg_ready` is 0 is dropped and sets `err_flag`.
- R8: An accepted strobe in cycle c gives `q_valid` = 1 for exactly one cycle, in cycle c+L, with `q_data` equal to the strobed `rd_data`. L = 3 + latch delay + first delay + second delay, which lies in 8..12.
- R9: Strobes on consecutive cycles give valid outputs on consecutive cycles, in order, with none lost.
- R10: Once set, `err_flag` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register address for write and read-back |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Read-back of the addressed register |
| rd_req | input | 1 | Column read strobe |
| rd_data | input | DATA_W | Read data word launched with the strobe |
| q_valid | output | 1 | Delayed word valid |
| q_data | output | DATA_W | Delayed read data word |
| cfg_ready | output | 1 | All timing registers have been loaded |
| err_flag | output | 1 | Sticky error: illegal write or early strobe |

## Verification
The hardest case to reach is the longest latency with the delay line completely full, so that every slot holds a word at once. The stimulus programs the largest legal values into both delay fields. It then sends a run of strobes on consecutive cycles, longer than the pipeline depth and each with a distinct data word. The reference model checks on every cycle that each word comes out exactly twelve cycles later and in order. The error paths need separate resets, because the sticky flag would otherwise hide later causes.

// File: rtl/rle_pkg.sv
`timescale 1ns/1ps
package rle_pkg;
  localparam int CFG_AW = 12;
  localparam int CFG_DW = 16;
  localparam logic [CFG_AW-1:0] ADDR_TIMING = 12'h048;
  localparam logic [CFG_AW-1:0] ADDR_FRAME  = 12'h049;
  localparam logic [CFG_AW-1:0] ADDR_DLY1   = 12'h04A;

  localparam int FIXED_LAT = 3;
  localparam int CORE_LAT  = 2;
  localparam int D0_MIN = 3, D0_MAX = 5;
  localparam int D1_MIN = 0, D1_MAX = 2;
  localparam int FR_MIN = 7, FR_MAX = 10;
  localparam int MAX_LAT = FIXED_LAT + CORE_LAT + D0_MAX + D1_MAX;

  typedef struct packed {
    logic [1:0] strb;
    logic [1:0] latch;
    logic [2:0] dly0;
    logic [3:0] frame;
    logic [2:0] dly1;
  } rle_cfg_t;

  function automatic logic timing_ok(input logic [CFG_DW-1:0] w);
    return (w[9:8] == 2'(CORE_LAT)) && (w[5:4] == 2'(CORE_LAT)) &&
           (int'(w[2:0]) >= D0_MIN) && (int'(w[2:0]) <= D0_MAX);
  endfunction

  function automatic logic frame_ok(input logic [CFG_DW-1:0] w);
    return (int'(w[3:0]) >= FR_MIN) && (int'(w[3:0]) <= FR_MAX);
  endfunction

  function automatic logic dly1_ok(input logic [CFG_DW-1:0] w);
    return (int'(w[2:0]) >= D1_MIN) && (int'(w[2:0]) <= D1_MAX);
  endfunction
endpackage

// File: rtl/rle_cfg_regs.sv
`timescale 1ns/1ps
module rle_cfg_regs
  import rle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] addr,
  input  logic [CFG_DW-1:0] wdata,
  output rle_cfg_t          cfg,
  output logic              ready,
  output logic              wr_bad,
  output logic [CFG_DW-1:0] rdata
);
  localparam int NREG = 3;

  logic [NREG-1:0] hit, ok, load;
  logic [NREG-1:0] seen_q, seen_d;
  rle_cfg_t        cfg_q;

  always_comb begin
    hit[0] = wr_en && (addr == ADDR_TIMING);
    hit[1] = wr_en && (addr == ADDR_FRAME);
    hit[2] = wr_en && (addr == ADDR_DLY1);
    ok[0]  = timing_ok(wdata);
    ok[1]  = frame_ok(wdata);
    ok[2]  = dly1_ok(wdata);
    load   = hit & ok;
    wr_bad = |(hit & ~ok);
    seen_d = seen_q | load;
  end

  // field storage: contents undefined until first legal write
  always_ff @(posedge clk) begin
    if (load[0]) begin
      cfg_q.strb  <= wdata[9:8];
      cfg_q.latch <= wdata[5:4];
      cfg_q.dly0  <= wdata[2:0];
    end
    if (load[1]) cfg_q.frame <= wdata[3:0];
    if (load[2]) cfg_q.dly1  <= wdata[2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_TIMING: begin
        rdata[9:8] = cfg_q.strb;
        rdata[5:4] = cfg_q.latch;
        rdata[2:0] = cfg_q.dly0;
      end
      ADDR_FRAME: rdata[3:0] = cfg_q.frame;
      ADDR_DLY1:  rdata[2:0] = cfg_q.dly1;
      default:    rdata = '0;
    endcase
  end

  assign cfg   = cfg_q;
  assign ready = &seen_q;
endmodule

// File: rtl/rle_admit.sv
`timescale 1ns/1ps
module rle_admit
  import rle_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic             ready,
  input  logic             wr_bad,
  input  logic [1:0]       latch,
  input  logic [2:0]       dly0,
  input  logic [2:0]       dly1,
  output logic             accept,
  output logic [LAT_W-1:0] lat,
  output logic             err
);
  logic err_q, err_d;

  always_comb begin
    accept = rd_req && ready;
    lat    = LAT_W'(FIXED_LAT) + LAT_W'(latch) + LAT_W'(dly0) + LAT_W'(dly1);
    err_d  = err_q | wr_bad | (rd_req & ~ready);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;
endmodule

// File: rtl/rle_delay_line.sv
`timescale 1ns/1ps
module rle_delay_line #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 12,
  parameter int LAT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LAT_W-1:0]  in_lat,
  output logic              out_vld,
  output logic [DATA_W-1:0] out_data
);
  logic [DEPTH-1:0]  vld_q, vld_d;
  logic [DATA_W-1:0] dat_q [DEPTH];
  logic [DATA_W-1:0] dat_d [DEPTH];

  // stage g is the entry point for latency DEPTH-g; stage DEPTH-1 drives out
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    localparam int unsigned SLOT = DEPTH - g;
    logic ins;
    always_comb begin
      ins = in_vld && (in_lat == LAT_W'(SLOT));
      if (ins) begin
        vld_d[g] = 1'b1;
        dat_d[g] = in_data;
      end else if (g == 0) begin
        vld_d[g] = 1'b0;
        dat_d[g] = dat_q[g];
      end else begin
        vld_d[g] = vld_q[(g == 0) ? 0 : g-1];
        dat_d[g] = dat_q[(g == 0) ? 0 : g-1];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[g] <= 1'b0;
      else        vld_q[g] <= vld_d[g];
    end

    always_ff @(posedge clk) begin
      if (vld_d[g]) dat_q[g] <= dat_d[g];
    end
  end

  assign out_vld  = vld_q[DEPTH-1];
  assign out_data = dat_q[DEPTH-1];
endmodule

// File: rtl/read_lat_equalizer.sv
`timescale 1ns/1ps
module read_lat_equalizer
  import rle_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [11:0]       cfg_addr,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rd_data,
  output logic              q_valid,
  output logic [DATA_W-1:0] q_data,
  output logic              cfg_ready,
  output logic              err_flag
);
  localparam int DEPTH = MAX_LAT;
  localparam int LAT_W = $clog2(DEPTH + 1);

  rle_cfg_t         cfg;
  logic             wr_bad;
  logic             accept;
  logic [LAT_W-1:0] lat;

  rle_cfg_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .ready (cfg_ready),
    .wr_bad(wr_bad),
    .rdata (cfg_rdata)
  );

  rle_admit #(.LAT_W(LAT_W)) u_admit (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_req(rd_req),
    .ready (cfg_ready),
    .wr_bad(wr_bad),
    .latch (cfg.latch),
    .dly0  (cfg.dly0),
    .dly1  (cfg.dly1),
    .accept(accept),
    .lat   (lat),
    .err   (err_flag)
  );

  rle_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LAT_W(LAT_W)) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (accept),
    .in_data (rd_data),
    .in_lat  (lat),
    .out_vld (q_valid),
    .out_data(q_data)
  );
endmodule

// File: rtl/read_lat_equalizer_chk.sv
`timescale 1ns/1ps
module read_lat_equalizer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic        q_valid,
  input logic        cfg_ready,
  input logic        err_flag,
  input logic [11:0] cfg_addr,
  input logic [15:0] cfg_rdata,
  input logic [2:0]  dly0,
  input logic [2:0]  dly1
);
  logic [7:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + {7'd0, rd_req && cfg_ready} - {7'd0, q_valid};
  end

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  a_r7_early_strobe_err: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !cfg_ready) |=> err_flag);
  a_r6_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> cfg_ready);
  a_r2_dly0_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> (dly0 >= 3'd3 && dly0 <= 3'd5));
  a_r4_dly1_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> (dly1 <= 3'd2));
  a_r5_frame_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr == 12'h049) |-> (cfg_rdata[15:4] == 12'd0));
  a_r8_output_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> (inflight != 8'd0));
endmodule

bind read_lat_equalizer read_lat_equalizer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_req   (rd_req),
  .q_valid  (q_valid),
  .cfg_ready(cfg_ready),
  .err_flag (err_flag),
  .cfg_addr (cfg_addr),
  .cfg_rdata(cfg_rdata),
  .dly0     (cfg.dly0),
  .dly1     (cfg.dly1)
);

// File: tb/read_lat_equalizer_tb_top.sv
`timescale 1ns/1ps
module read_lat_equalizer_tb_top;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_wr;
  logic [11:0]   cfg_addr;
  logic [15:0]   cfg_wdata;
  logic [15:0]   cfg_rdata;
  logic          rd_req;
  logic [DW-1:0] rd_data;
  logic          q_valid;
  logic [DW-1:0] q_data;
  logic          cfg_ready;
  logic          err_flag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  read_lat_equalizer #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rd_req(rd_req),
    .rd_data(rd_data), .q_valid(q_valid), .q_data(q_data),
    .cfg_ready(cfg_ready), .err_flag(err_flag)
  );

  // reference model state
  int      m_strb, m_latch, m_d0, m_frame, m_d1;
  bit      m_seen[3];
  bit      m_err;
  bit      mv[16];
  logic [DW-1:0] md[16];
  int      vld_seen;

  function automatic bit m_ready();
    return m_seen[0] && m_seen[1] && m_seen[2];
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    foreach (m_seen[i]) m_seen[i] = 0;
    m_err = 0;
    foreach (mv[i]) mv[i] = 0;
  endtask

  // model update for one rising edge, using inputs applied before it
  task automatic model_edge();
    bit acc;
    int lat;
    acc = rd_req && m_ready();
    if (rd_req && !m_ready()) m_err = 1;
    lat = 3 + m_latch + m_d0 + m_d1;
    for (int i = 0; i < 15; i++) begin mv[i] = mv[i+1]; md[i] = md[i+1]; end
    mv[15] = 0;
    if (acc) begin mv[lat-1] = 1; md[lat-1] = rd_data; end
    if (cfg_wr) begin
      case (cfg_addr)
        12'h048: begin
          int s, l, d;
          s = cfg_wdata[9:8]; l = cfg_wdata[5:4]; d = cfg_wdata[2:0];
          if (s == 2 && l == 2 && d >= 3 && d <= 5) begin
            m_strb = s; m_latch = l; m_d0 = d; m_seen[0] = 1;
          end else m_err = 1;
        end
        12'h049: begin
          int f;
          f = cfg_wdata[3:0];
          if (f >= 7 && f <= 10) begin m_frame = f; m_seen[1] = 1; end
          else m_err = 1;
        end
        12'h04A: begin
          int d;
          d = cfg_wdata[2:0];
          if (d <= 2) begin m_d1 = d; m_seen[2] = 1; end
          else m_err = 1;
        end
        default: ;
      endcase
    end
  endtask

  function automatic int model_rdata();
    case (cfg_addr)
      12'h048: return (m_strb << 8) | (m_latch << 4) | m_d0;
      12'h049: return m_frame;
      12'h04A: return m_d1;
      default: return 0;
    endcase
  endfunction

  function automatic bit rdata_known();
    case (cfg_addr)
      12'h048: return m_seen[0];
      12'h049: return m_seen[1];
      12'h04A: return m_seen[2];
      default: return 1;
    endcase
  endfunction

  // one clock: edge, model update, compare at the falling edge
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check("R8 q_valid", q_valid, mv[0]);
    if (mv[0]) check("R8 R9 q_data", q_data, md[0]);
    if (q_valid) vld_seen++;
    check("R7 R10 err_flag", err_flag, m_err);
    check("R6 cfg_ready", cfg_ready, m_ready());
    if (rdata_known()) check("R5 cfg_rdata", cfg_rdata, model_rdata());
  endtask

  task automatic idle();
    cfg_wr = 0; rd_req = 0;
  endtask

  task automatic do_reset();
    idle();
    cfg_addr = 12'h000; cfg_wdata = '0; rd_data = '0;
    rst_n = 0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    cfg_wr = 1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 0;
  endtask

  task automatic configure(input int d0, input int d1);
    wr(12'h048, 16'h0220 | 16'(d0));
    wr(12'h049, 16'd8);
    wr(12'h04A, 16'(d1));
  endtask

  task automatic measure(input int exp_lat, input logic [DW-1:0] d, input string tag);
    int n;
    n = 0;
    rd_req = 1; rd_data = d;
    tick(); n++;
    rd_req = 0;
    while (!q_valid && n < 20) begin tick(); n++; end
    check(tag, n, exp_lat);
    check({tag, " data"}, q_data, d);
    tick();
    check({tag, " single pulse"}, q_valid, 0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: reset state
    check("R1 q_valid", q_valid, 0);
    check("R1 err_flag", err_flag, 0);
    check("R1 cfg_ready", cfg_ready, 0);

    // R7: strobe before configuration dropped, error raised
    rd_req = 1; rd_data = 32'hDEAD0001;
    tick(); idle();
    check("R7 err after early strobe", err_flag, 1);
    vld_seen = 0;
    repeat (14) tick();
    check("R7 dropped strobe yields no output", vld_seen, 0);
    check("R10 err still set", err_flag, 1);

    // R6 / R2 / R5: clean configuration, minimum latency
    do_reset();
    wr(12'h048, 16'hF223);
    cfg_addr = 12'h048; #1;
    check("R5 unused bits read zero", cfg_rdata, 16'h0223);
    wr(12'h049, 16'hFFF7);
    check("R6 not ready after two regs", cfg_ready, 0);
    wr(12'h04B, 16'hFFFF);
    cfg_addr = 12'h04B; #1;
    check("R5 unmapped reads zero", cfg_rdata, 0);
    check("R5 unmapped write no error", err_flag, 0);
    wr(12'h04A, 16'h0000);
    check("R6 ready after all three", cfg_ready, 1);
    measure(8, 32'hA5A50008, "R8 latency 8");

    // illegal writes
    wr(12'h048, 16'h0226);
    cfg_addr = 12'h048; #1;
    check("R2 illegal dly0 ignored", cfg_rdata, 16'h0223);
    check("R2 illegal dly0 err", err_flag, 1);
    wr(12'h048, 16'h0123);
    cfg_addr = 12'h048; #1;
    check("R2 illegal strobe field ignored", cfg_rdata, 16'h0223);
    wr(12'h049, 16'h0006);
    cfg_addr = 12'h049; #1;
    check("R3 illegal frame ignored", cfg_rdata, 16'h0007);
    wr(12'h049, 16'h000B);
    cfg_addr = 12'h049; #1;
    check("R3 frame above range ignored", cfg_rdata, 16'h0007);
    wr(12'h04A, 16'h0003);
    cfg_addr = 12'h04A; #1;
    check("R4 illegal dly1 ignored", cfg_rdata, 16'h0000);
    measure(8, 32'h5A5A0008, "R4 latency unchanged");
    check("R10 err sticky", err_flag, 1);

    // R3 / R4 separately from a clean error state
    do_reset();
    configure(3, 0);
    wr(12'h04A, 16'h0007);
    check("R4 illegal dly1 err", err_flag, 1);
    do_reset();
    configure(3, 0);
    wr(12'h049, 16'h0000);
    check("R3 illegal frame err", err_flag, 1);

    // R9: full pipeline at maximum latency
    do_reset();
    configure(5, 2);
    check("R2 R4 max config no err", err_flag, 0);
    measure(12, 32'h0000000C, "R8 latency 12");
    vld_seen = 0;
    for (int i = 0; i < 20; i++) begin
      rd_req = 1; rd_data = 32'hB000_0000 + 32'(i);
      tick();
    end
    idle();
    repeat (14) tick();
    check("R9 all burst words delivered", vld_seen, 20);

    // mid latency with a gapped pattern
    do_reset();
    configure(4, 1);
    measure(10, 32'h0000000A, "R8 latency 10");
    vld_seen = 0;
    for (int i = 0; i < 24; i++) begin
      rd_req = (i % 3 != 1); rd_data = 32'hC000_0000 + 32'(i);
      tick();
    end
    idle();
    repeat (14) tick();
    check("R9 gapped words delivered", vld_seen, 16);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule